// File: doc/BRIEF.md
# Prescaled Real-Time Wrap Counter

This block keeps time from a slow reference. Two slow clock sources, each given as a one-cycle enable pulse in the system clock domain, feed a hidden 16-bit prescaler. A control bit picks which source drives it. A 4-bit tap field picks one prescaler bit. Each rising transition of that bit is one count tick, so ticks arrive at the source rate divided by 2^(tap+1). A 32-bit counter counts the ticks up to a programmable limit. On the tick after the limit it returns to zero and sets a sticky wrap flag. An interrupt output shows the flag when the interrupt enable is set.

Software uses a plain register port: one address bus, a write strobe, write data, and combinational read data. It can start and stop the block, clear the prescaler, and load the counter and the limit at any time. While a debug halt input is high the prescaler holds its value, unless a keep-running input is also high.

Top module: `rtc_wrap_counter`

## Requirements
- R1: When the run bit (CTRL bit 0) is zero, source pulses change neither the prescaler nor the counter.
- R2: The prescaler is 16 bits wide and advances by one on each cycle in which the selected source pulse is high. With tap 15, the first tick after a prescaler clear comes on the 32768th pulse.
- R3: Writing CTRL with bit 1 set resets the prescaler to zero. That bit reads back as zero. After a clear, the first tick comes on pulse 2^tap.
- R4: CTRL bit 2 selects the source: 0 takes `src_rc_pulse`, 1 takes `src_xo_pulse`. Pulses on the other source are ignored.
- R5: The tap field CTRL[11:8] selects prescaler bit `tap`. Each 0-to-1 transition of that bit is a tick, so ticks repeat every 2^(tap+1) pulses.
- R6: On a tick, the counter (address 1) goes up by one, except when it equals TOP (address 2). In that case it goes to zero.
- R7: Counting from zero, the counter returns to zero after exactly TOP+1 ticks.
- R8: A wrap sets the status flag (address 4, bit 0). The flag stays set until software writes a one to bit 0 of the clear register (address 5).
- R9: `irq` equals the status flag ANDed with the interrupt enable (address 3, bit 0).
- R10: While `dbg_halt` is high and `dbg_keep_run` is low, the prescaler holds its value. While both are high, counting goes on normally.
- R11: If a wrap and a flag-clear write fall in the same cycle, the flag ends up set.
- R12: A write to the counter takes effect on the next edge and overrides a tick in the same cycle.
- R13: After reset, CTRL, the counter, the interrupt enable and the status flag read 0, and TOP reads 0xFFFFFFFF. CTRL, TOP and the interrupt enable read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_rc_pulse | input | 1 | Enable pulse from the RC-derived source |
| src_xo_pulse | input | 1 | Enable pulse from the 32 kHz source |
| dbg_halt | input | 1 | Debug halt; freezes the prescaler |
| dbg_keep_run | input | 1 | Keeps the prescaler running during debug halt |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Wrap interrupt request |

## Verification
The assertions assume that each source pulse is already synchronous to `clk`, and that a level held high for n cycles means n input edges. They also assume that `reg_wdata` is defined whenever `reg_wr` is high. They allow a counter write, a flag clear and a tick to land in the same cycle, since the priority rules are defined for those overlaps. The stimulus drives every input at the falling edge in whole-cycle units and writes one register per strobe. It sets up the overlaps on purpose: a counter write together with a tick, and a flag clear together with a wrap.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned PRESC_W = 16;
  localparam int unsigned TAP_W   = 4;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] RA_TOP   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CLR   = 3'd5;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_PCLR   = 1;
  localparam int unsigned CB_SRC    = 2;
  localparam int unsigned CB_TAP_LO = 8;

  typedef struct packed {
    logic             run;
    logic             src;
    logic [TAP_W-1:0] tap;
  } ctrl_t;
endpackage

// File: rtl/rtcw_regs.sv
module rtcw_regs
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              flag_val,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] top_val,
  output logic              ien,
  output logic              presc_clr,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] cnt_wdata,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);
  logic sel_ctrl, sel_top, sel_ien;

  assign sel_ctrl = wr && (addr == RA_CTRL);
  assign sel_top  = wr && (addr == RA_TOP);
  assign sel_ien  = wr && (addr == RA_IEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      top_val <= '1;
      ien     <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        ctrl.run <= wdata[CB_RUN];
        ctrl.src <= wdata[CB_SRC];
        ctrl.tap <= wdata[CB_TAP_LO +: TAP_W];
      end
      if (sel_top) top_val <= wdata;
      if (sel_ien) ien <= wdata[0];
    end
  end

  assign presc_clr = sel_ctrl && wdata[CB_PCLR];
  assign cnt_wr    = wr && (addr == RA_COUNT);
  assign cnt_wdata = wdata;
  assign flag_clr  = wr && (addr == RA_CLR) && wdata[0];

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CB_RUN]               = ctrl.run;
        rdata[CB_SRC]               = ctrl.src;
        rdata[CB_TAP_LO +: TAP_W]   = ctrl.tap;
      end
      RA_COUNT: rdata    = cnt_val;
      RA_TOP:   rdata    = top_val;
      RA_IEN:   rdata[0] = ien;
      RA_STAT:  rdata[0] = flag_val;
      default:  rdata    = '0;
    endcase
  end
endmodule

// File: rtl/rtcw_prescaler.sv
module rtcw_prescaler #(
  parameter int unsigned PW = 16,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          src_sel,
  input  logic          src_a,
  input  logic          src_b,
  input  logic          halt,
  input  logic          keep,
  input  logic          clr,
  input  logic [TW-1:0] tap,
  output logic          tick
);
  localparam int unsigned NTAP = 1 << TW;

  logic [PW-1:0]   presc_q, presc_nx;
  logic [NTAP-1:0] rise;
  logic            pulse, frozen, adv;

  assign pulse    = src_sel ? src_b : src_a;
  assign frozen   = halt && !keep;
  assign adv      = run && pulse && !frozen;
  assign presc_nx = presc_q + 1'b1;

  for (genvar i = 0; i < NTAP; i++) begin : g_rise
    if (i < PW) begin : g_bit
      assign rise[i] = !presc_q[i] && presc_nx[i];
    end else begin : g_none
      assign rise[i] = 1'b0;
    end
  end

  assign tick = adv && !clr && rise[tap];

  always_ff @(posedge clk) begin
    if (!rst_n)   presc_q <= '0;
    else if (clr) presc_q <= '0;
    else if (adv) presc_q <= presc_nx;
  end

  AST_PCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (presc_q == '0)); // R3
  AST_DBG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !keep && !clr) |=> $stable(presc_q)); // R10
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(presc_q)); // R1
endmodule

// File: rtl/rtcw_counter.sv
module rtcw_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] top,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt_q,
  output logic          flag_q
);
  logic at_top, wrap;

  assign at_top = (cnt_q == top);
  assign wrap   = tick && !wr && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wr)   cnt_q <= wdata;
    else if (tick) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q == top) |=> (cnt_q == '0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R8
  AST_WRAP_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q == top && flag_clr) |=> flag_q); // R11
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wdata))); // R12
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_rc_pulse,
  input  logic              src_xo_pulse,
  input  logic              dbg_halt,
  input  logic              dbg_keep_run,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] top_val, cnt_val, cnt_wdata;
  logic              ien, presc_clr, cnt_wr, flag_clr, flag_val, tick;

  rtcw_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .cnt_val   (cnt_val),
    .flag_val  (flag_val),
    .ctrl      (ctrl),
    .top_val   (top_val),
    .ien       (ien),
    .presc_clr (presc_clr),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .flag_clr  (flag_clr),
    .rdata     (reg_rdata)
  );

  rtcw_prescaler #(.PW(PRESC_W), .TW(TAP_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .src_sel (ctrl.src),
    .src_a   (src_rc_pulse),
    .src_b   (src_xo_pulse),
    .halt    (dbg_halt),
    .keep    (dbg_keep_run),
    .clr     (presc_clr),
    .tap     (ctrl.tap),
    .tick    (tick)
  );

  rtcw_counter #(.CW(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr       (cnt_wr),
    .wdata    (cnt_wdata),
    .top      (top_val),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_val),
    .flag_q   (flag_val)
  );

  assign irq = flag_val && ien;

  AST_IDLE_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cnt_wr) |=> $stable(cnt_val)); // R1
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_val); // R9
endmodule

// File: tb/rtc_wrap_counter_test.sv
module rtc_wrap_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc = 1'b0, xo = 1'b0, halt = 1'b0, keep = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_pin;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #4ns clk = ~clk;

  rtc_wrap_counter uut (
    .clk(clk), .rst_n(rst_n), .src_rc_pulse(rc), .src_xo_pulse(xo),
    .dbg_halt(halt), .dbg_keep_run(keep), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  // monitor: pops expected items and compares after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2ns;
      if (sb.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_pin ? {31'b0, irq} : rdata;
        vectors++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] ctl(bit run, bit pclr, bit src, int tap);
    return (32'(tap) << 8) | (32'(src) << 2) | (32'(pclr) << 1) | 32'(run);
  endfunction

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a; wr = 1'b0;
    it.is_pin = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #3ns;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.is_pin = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #3ns;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wreg_pulse(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rc = 1'b1;
    @(negedge clk);
    wr = 1'b0; rc = 1'b0;
  endtask

  task automatic burst(input int n, input bit use_xo);
    @(negedge clk);
    if (use_xo) xo = 1'b1; else rc = 1'b1;
    repeat (n) @(negedge clk);
    rc = 1'b0; xo = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk(3'd0, 32'h0, "R13 ctrl reset");
    chk(3'd1, 32'h0, "R13 count reset");
    chk(3'd2, 32'hFFFF_FFFF, "R13 top reset");
    chk(3'd4, 32'h0, "R13 status reset");
    chk_irq(1'b0, "R13 irq reset");
    wreg(3'd2, 32'd3);
    chk(3'd2, 32'd3, "R13 top readback");
    wreg(3'd3, 32'd1);
    chk(3'd3, 32'd1, "R13 ien readback");
    wreg(3'd0, ctl(1, 1, 0, 0));
    chk(3'd0, 32'h1, "R13 ctrl readback, clear bit reads 0");
    // tap 0: tick every 2 pulses, first on pulse 1
    burst(1, 0); chk(3'd1, 32'd1, "R5 first tick tap0");
    burst(2, 0); chk(3'd1, 32'd2, "R6 increment");
    burst(2, 0); chk(3'd1, 32'd3, "R6 reach top");
    chk(3'd4, 32'd0, "R8 no flag before wrap");
    burst(2, 0); chk(3'd1, 32'd0, "R6 wrap to zero");
    chk(3'd4, 32'd1, "R8 flag set on wrap");
    chk_irq(1'b1, "R9 irq with enable");
    burst(7, 0); chk(3'd1, 32'd3, "R7 three ticks later");
    burst(1, 0); chk(3'd1, 32'd0, "R7 period top+1");
    burst(6, 1); chk(3'd1, 32'd0, "R4 unselected source ignored");
    wreg(3'd3, 32'd0);
    chk_irq(1'b0, "R9 irq masked");
    chk(3'd4, 32'd1, "R8 flag still set");
    wreg(3'd5, 32'd1);
    chk(3'd4, 32'd0, "R8 flag cleared");
    // tap 2
    wreg(3'd0, ctl(1, 1, 0, 2));
    wreg(3'd1, 32'd0);
    burst(3, 0); chk(3'd1, 32'd0, "R5 tap2 no tick before 4");
    burst(1, 0); chk(3'd1, 32'd1, "R5 tap2 tick at 4");
    burst(7, 0); chk(3'd1, 32'd1, "R5 tap2 no tick within 8");
    burst(1, 0); chk(3'd1, 32'd2, "R5 tap2 tick after 8");
    burst(2, 0);
    wreg(3'd0, ctl(1, 1, 0, 2));
    burst(3, 0); chk(3'd1, 32'd2, "R3 clear restarts prescaler");
    burst(1, 0); chk(3'd1, 32'd3, "R3 tick after clear at 4");
    // debug
    halt = 1'b1;
    burst(20, 0); chk(3'd1, 32'd3, "R10 frozen in debug");
    keep = 1'b1;
    burst(7, 0); chk(3'd1, 32'd3, "R10 prescaler kept value");
    burst(1, 0); chk(3'd1, 32'd0, "R10 override runs");
    halt = 1'b0; keep = 1'b0;
    wreg(3'd5, 32'd1);
    // disabled
    wreg(3'd0, ctl(0, 0, 0, 2));
    burst(20, 0); chk(3'd1, 32'd0, "R1 stopped when disabled");
    chk(3'd0, 32'h200, "R13 ctrl tap readback");
    // write priority
    wreg(3'd0, ctl(1, 1, 0, 0));
    wreg_pulse(3'd1, 32'd100);
    chk(3'd1, 32'd100, "R12 write beats tick");
    burst(1, 0); burst(1, 0);
    chk(3'd1, 32'd101, "R12 counting resumes");
    // wrap vs clear
    wreg(3'd1, 32'd3);
    burst(1, 0);
    wreg(3'd5, 32'd0);
    chk(3'd4, 32'd0, "R8 clear write of 0 harmless");
    wreg_pulse(3'd5, 32'd1);
    chk(3'd4, 32'd1, "R11 wrap beats clear");
    chk(3'd1, 32'd0, "R11 counter wrapped");
    wreg(3'd5, 32'd1);
    chk(3'd4, 32'd0, "R8 cleared after");
    // second source
    wreg(3'd0, ctl(1, 1, 1, 0));
    burst(4, 0); chk(3'd1, 32'd0, "R4 rc ignored when xo selected");
    burst(1, 1); chk(3'd1, 32'd1, "R4 xo source ticks");
    // full-width tap
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd0, ctl(1, 1, 1, 15));
    burst(32767, 1); chk(3'd1, 32'd1, "R2 no tick before 32768");
    burst(1, 1); chk(3'd1, 32'd2, "R2 tick on 32768th pulse");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule